// File: doc/BRIEF.md
# Averaging Offset/Gain Calibration Engine

This block sits between a converter's decimation filter and its output register. It receives one filtered conversion result per conversion period, signalled by a one-cycle valid strobe. In normal operation each result has the stored offset subtracted and is then multiplied by the stored gain. The outcome is saturated to the sample width and announced by a one-cycle low pulse on an active-low data-ready output.

A command input starts three procedures. A sync command holds data-ready inactive while the filter settles. An offset command averages the next sixteen raw results, which are taken with a zero input applied, and writes the mean into the offset coefficient. A gain command averages the next sixteen offset-corrected results, which are taken with a full-scale input applied. A sequential divider then divides the nominal full-scale code by that mean to form the gain coefficient. The gain step assumes the offset has already been calibrated. While any procedure runs, data-ready stays high and further commands are dropped.

Top module: `avg_cal_engine`

## Requirements
- R1: After reset, data-ready is high, the output sample is 0, the offset coefficient is 0 and the gain coefficient is 1.0, which is 65536 with 16 fraction bits.
- R2: In normal operation each valid strobe causes data-ready to go low for exactly the following cycle. In that cycle the output equals floor((sample − offset) × gain / 65536). Between pulses the output holds its value.
- R3: Command code 2'b01 (sync) discards the next 64 valid strobes without any data-ready pulse. The 65th strobe is processed normally.
- R4: Command code 2'b10 (offset calibrate) accumulates the raw samples of the next 16 strobes. It stores floor(sum/16) as the offset. Data-ready goes low for one cycle in the cycle the new offset appears, and stays high during the 16 strobes.
- R5: Command code 2'b11 (gain calibrate) accumulates (sample − offset) over the next 16 strobes and takes avg = floor(sum/16). It sets gain = min(floor(32767 × 65536 / avg), 262143), or 262143 when avg ≤ 0. Data-ready goes low for one cycle in the cycle the new gain appears. Code 2'b00 means no command.
- R6: A command that arrives while a settle window, an averaging window or the division is running has no effect on the coefficients or on the running procedure.
- R7: A corrected result above 32767 is output as 32767, and one below −32768 is output as −32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | One-cycle strobe: a new filtered result is present |
| conv_data | input | 16 | Signed filtered conversion result |
| cmd | input | 2 | Command: 00 none, 01 sync, 10 offset cal, 11 gain cal |
| drdy_n | output | 1 | Active-low data-ready pulse |
| out_data | output | 16 | Signed corrected, saturated output sample |
| offset_coef | output | 16 | Signed offset coefficient |
| gain_coef | output | 18 | Unsigned gain coefficient, 16 fraction bits |

## Verification
The averaging path is tested with a spread of positive readings, which checks that every sample enters the sum. A set of negative readings with a non-multiple-of-16 sum separates a flooring shift from a truncating one. The gain path is driven with large readings taken after a negative offset, which shows whether the offset is subtracted before the division. Readings equal to the stored offset give a zero mean and expose the clamp. Commands injected mid-window and mid-division, followed by a single sample, show whether a busy procedure was disturbed or a new one started.

// File: rtl/avg_cal_engine.sv
module avg_cal_engine #(
  parameter int DW        = 16,
  parameter int NAVG_LOG2 = 4,
  parameter int SETTLE_N  = 64,
  parameter int FRAC      = 16,
  parameter int GW        = FRAC + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_valid,
  input  logic signed [DW-1:0] conv_data,
  input  logic [1:0]           cmd,
  output logic                 drdy_n,
  output logic signed [DW-1:0] out_data,
  output logic signed [DW-1:0] offset_coef,
  output logic [GW-1:0]        gain_coef
);
  localparam int NAVG = 1 << NAVG_LOG2;
  localparam int AW   = DW + 1 + NAVG_LOG2;
  localparam int QW   = DW - 1 + FRAC;
  localparam int CMAX = (SETTLE_N > QW) ? ((SETTLE_N > NAVG) ? SETTLE_N : NAVG)
                                        : ((QW > NAVG) ? QW : NAVG);
  localparam int CNTW = $clog2(CMAX + 1);
  localparam int PW   = DW + GW + 2;
  localparam logic [GW-1:0] G_ONE = GW'(1) << FRAC;
  localparam logic [GW-1:0] G_MAX = '1;
  localparam logic [QW-1:0] DVD   = {{(DW-1){1'b1}}, {FRAC{1'b0}}};
  localparam logic signed [PW-1:0] HI = {{(GW+3){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = ~HI;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_OFS, S_GAIN, S_DIV} st_t;
  st_t state;
  logic [CNTW-1:0] cnt;
  logic signed [AW-1:0] acc;
  logic [DW:0] rem, dvs;
  logic [QW-1:0] dvd;
  logic [QW-2:0] quo;

  logic busy, in_div;
  assign busy   = (state != S_IDLE);
  assign in_div = (state == S_DIV);

  logic signed [DW:0] diff, term;
  logic signed [PW-1:0] prod, scaled;
  logic signed [DW-1:0] sat;
  assign diff   = {conv_data[DW-1], conv_data} - {offset_coef[DW-1], offset_coef};
  assign prod   = diff * $signed({1'b0, gain_coef});
  assign scaled = prod >>> FRAC;
  assign sat    = (scaled > HI) ? HI[DW-1:0] : (scaled < LO) ? LO[DW-1:0] : scaled[DW-1:0];

  logic signed [AW-1:0] acc_nx;
  logic signed [DW:0] avg;
  assign term   = (state == S_GAIN) ? diff : {conv_data[DW-1], conv_data};
  assign acc_nx = acc + {{NAVG_LOG2{term[DW]}}, term};
  assign avg    = acc_nx[AW-1:NAVG_LOG2];

  logic [DW+1:0] trial;
  logic [DW:0] sub;
  logic ge;
  logic [QW-1:0] q_fin;
  assign trial = {rem, dvd[QW-1]};
  assign ge    = trial >= {1'b0, dvs};
  assign sub   = trial[DW:0] - dvs;
  assign q_fin = {quo, ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  cnt <= '0;  acc <= '0;
      drdy_n <= 1'b1;   out_data <= '0;
      offset_coef <= '0; gain_coef <= G_ONE;
      rem <= '0; dvs <= '0; dvd <= '0; quo <= '0;
    end else begin
      drdy_n <= 1'b1;
      if (!busy) begin
        cnt <= '0;
        acc <= '0;
        case (cmd)
          2'b01:   state <= S_SETTLE;
          2'b10:   state <= S_OFS;
          2'b11:   state <= S_GAIN;
          default: if (conv_valid) begin
            out_data <= sat;
            drdy_n   <= 1'b0;
          end
        endcase
      end else if (in_div) begin
        rem <= ge ? sub : trial[DW:0];
        dvd <= dvd << 1;
        quo <= q_fin[QW-2:0];
        cnt <= cnt + CNTW'(1);
        if (cnt == CNTW'(QW-1)) begin
          gain_coef <= (|q_fin[QW-1:GW]) ? G_MAX : q_fin[GW-1:0];
          drdy_n    <= 1'b0;
          state     <= S_IDLE;
        end
      end else if (conv_valid) begin
        cnt <= cnt + CNTW'(1);
        if (state == S_SETTLE) begin
          if (cnt == CNTW'(SETTLE_N-1)) state <= S_IDLE;
        end else begin
          acc <= acc_nx;
          if (cnt == CNTW'(NAVG-1)) begin
            cnt <= '0;
            if (state == S_OFS) begin
              offset_coef <= avg[DW-1:0];
              drdy_n      <= 1'b0;
              state       <= S_IDLE;
            end else if (avg[DW] || avg == '0) begin
              gain_coef <= G_MAX;
              drdy_n    <= 1'b0;
              state     <= S_IDLE;
            end else begin
              dvs   <= avg;
              rem   <= '0;
              dvd   <= DVD;
              quo   <= '0;
              state <= S_DIV;
            end
          end
        end
      end
    end
  end
endmodule

module avg_cal_engine_chk #(
  parameter int DW = 16,
  parameter int GW = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 conv_valid,
  input logic                 drdy_n,
  input logic signed [DW-1:0] out_data,
  input logic signed [DW-1:0] offset_coef,
  input logic [GW-1:0]        gain_coef,
  input logic                 busy,
  input logic                 in_div
);
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_n |-> $stable(out_data));
  p_drdy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_n |-> ($past(conv_valid) || $past(in_div)));
  p_quiet_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> drdy_n);
  p_ofs_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_coef) |-> !drdy_n);
  p_gain_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_coef) |-> !drdy_n);
  p_gain_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gain_coef != '0);
endmodule

bind avg_cal_engine avg_cal_engine_chk #(.DW(DW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .drdy_n(drdy_n),
  .out_data(out_data), .offset_coef(offset_coef), .gain_coef(gain_coef),
  .busy(busy), .in_div(in_div));

// File: tb/avg_cal_engine_tb.sv
module avg_cal_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0, conv_valid = 1'b0;
  logic signed [15:0] conv_data = '0;
  logic [1:0] cmd = 2'b00;
  logic drdy_n;
  logic signed [15:0] out_data, offset_coef;
  logic [17:0] gain_coef;
  int nchk = 0, nerr = 0;
  longint m_ofs = 0, m_gain = 65536;

  always #5 clk = ~clk;

  avg_cal_engine u_dut (.clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
    .conv_data(conv_data), .cmd(cmd), .drdy_n(drdy_n), .out_data(out_data),
    .offset_coef(offset_coef), .gain_coef(gain_coef));

  task automatic chk(input string req, input longint got, input longint exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint model_out(input longint x);
    longint v = ((x - m_ofs) * m_gain) >>> 16;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic sample(input longint x, output bit low, output longint o);
    @(negedge clk); conv_valid = 1'b1; conv_data = 16'(x);
    @(negedge clk); conv_valid = 1'b0;
    low = !drdy_n; o = out_data;
  endtask

  task automatic command(input logic [1:0] c);
    @(negedge clk); cmd = c;
    @(negedge clk); cmd = 2'b00;
  endtask

  task automatic normal_sample(input string req, input longint x);
    bit low; longint o;
    sample(x, low, o);
    chk({req, " drdy"}, low, 1);
    chk({req, " out"}, o, model_out(x));
  endtask

  task automatic t_reset;
    chk("R1 drdy_n", drdy_n, 1);
    chk("R1 out_data", out_data, 0);
    chk("R1 offset", offset_coef, 0);
    chk("R1 gain", gain_coef, 65536);
  endtask

  task automatic t_normal;
    normal_sample("R2 pos", 1234);
    normal_sample("R2 neg", -5000);
    repeat (3) @(negedge clk);
    chk("R2 pulse width", drdy_n, 1);
    chk("R2 hold", out_data, -5000);
  endtask

  task automatic t_sync;
    bit low; longint o; int lows = 0;
    command(2'b01);
    for (int i = 0; i < 64; i++) begin
      sample(i, low, o);
      if (low) lows++;
    end
    chk("R3 silent strobes", lows, 0);
    normal_sample("R3 first after settle", 77);
  endtask

  task automatic t_ofs(input string req, input longint base, input bit inject);
    bit low; longint o, sum = 0; int lows = 0; longint x;
    command(2'b10);
    for (int i = 0; i < 16; i++) begin
      x = (base < 0) ? ((i == 15) ? base - 1 : base) : base + (i % 7);
      sum += x;
      if (inject && i == 5) begin command(2'b01); command(2'b11); end
      sample(x, low, o);
      if (i < 15 && low) lows++;
      if (i == 15) chk({req, " drdy at update"}, low, 1);
    end
    chk({req, " quiet window"}, lows, 0);
    m_ofs = sum >>> 4;
    chk({req, " offset"}, offset_coef, m_ofs);
    normal_sample({req, " corrected"}, 500);
  endtask

  task automatic t_gain(input string req, input longint base, input bit inject);
    bit low; longint o, sum = 0, avg, x; int lows = 0, waitc = 0;
    command(2'b11);
    for (int i = 0; i < 16; i++) begin
      x = (base == 0) ? m_ofs : base + 3 * i;
      sum += x - m_ofs;
      sample(x, low, o);
      if (low) lows++;
    end
    avg = sum >>> 4;
    if (avg <= 0) m_gain = 262143;
    else begin
      m_gain = (64'd32767 * 64'd65536) / avg;
      if (m_gain > 262143) m_gain = 262143;
    end
    if (avg > 0) begin
      chk({req, " quiet window"}, lows, 0);
      if (inject) command(2'b10);
      while (drdy_n && waitc < 200) begin @(negedge clk); waitc++; end
    end else chk({req, " drdy at update"}, lows, 1);
    chk({req, " done"}, drdy_n, 0);
    chk({req, " gain"}, gain_coef, m_gain);
    normal_sample({req, " corrected"}, 12000);
  endtask

  task automatic t_sat;
    normal_sample("R7 high clamp", 32767);
    normal_sample("R7 low clamp", -32768);
    chk("R7 hi value", model_out(32767), 32767);
    chk("R7 lo value", model_out(-32768), -32768);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_normal;
    t_sync;
    t_ofs("R4 positive", 100, 1'b0);
    t_ofs("R6 R4 negative", -3, 1'b1);
    t_gain("R5 R6 fullscale", 20000, 1'b1);
    t_sat;
    t_gain("R5 zero mean", 0, 1'b0);
    t_gain("R5 restore", 24000, 1'b0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule